// File: doc/BRIEF.md
# Serial Port Receive Interrupt Controller

This block sits on the receive side of a synchronous serial port. Each frame the shifter finishes is written into a small receive queue. Software or a DMA engine drains the queue through a read strobe, and the head entry is always shown on the read data port.

The block raises two receive interrupts of its own:
- **Timeout.** It asserts when data has sat unread while the line has been quiet for a fixed number of bit periods.
- **Overrun.** It asserts when a frame completes with no room left in the queue.

After an overrun, every later frame is dropped until software writes a one to the clear input. Two further raw sources from the port's transmit and receive-level service logic pass through the same per-source mask. A single combined line reports any masked source.

The idle counter advances only on bit-rate ticks while no transfer is in flight. Any transfer start, completed frame, queue read or overrun clear restarts it. The same rules apply whichever end of the link drives the serial clock.

Top module: `spRxIrq`

## Requirements
- R1: After reset the queue is empty, `rxNotEmpty` is 0, and `rawIrq`, `maskedIrq` and `combIrq` are all 0.
- R2: The queue holds `DEPTH` (8) frames in arrival order, and `rdData` shows the oldest entry. A read strobe removes it. A read strobe while the queue is empty has no effect.
- R3: `rawIrq[0]` (timeout) rises right after the `IDLE_BITS`-th (32nd) qualifying bit tick with the queue non-empty. It is still 0 after 31 ticks.
- R4: A transfer start drops the timeout on the next cycle. Ticks that arrive between a transfer start and its frame completion are not counted.
- R5: A queue read restarts the idle count. If data remains, the timeout returns only after another 32 ticks.
- R6: `rawIrq[1]` (overrun) rises in the cycle after a frame completes while the queue is full and no read happens in that cycle. The transfer start alone does not raise it. The overflowing frame is discarded.
- R7: If a read frees a slot before the overflowing frame completes, that frame is stored in order and no overrun is raised.
- R8: While the overrun is set, every completed frame is discarded. A one on `ovrClr` drops the overrun, and later frames are stored again.
- R9: An overrun clear restarts the idle count. With data still queued, the timeout rises 32 ticks after the clear and not before.
- R10: `rawIrq` bit map: bit 0 timeout, bit 1 overrun, bit 2 `extRaw[0]`, bit 3 `extRaw[1]`. `maskedIrq` is `rawIrq` gated by `maskEn` bit by bit, and `combIrq` is 1 exactly when any `maskedIrq` bit is 1.
- R11: With the queue empty the timeout never asserts, whatever the number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameDone | input | 1 | Frame completion strobe |
| frameData | input | DW | Received frame word, valid with `frameDone` |
| xferStart | input | 1 | Transfer start strobe |
| bitTick | input | 1 | One pulse per serial bit period |
| rdEn | input | 1 | Queue read strobe |
| ovrClr | input | 1 | Write-1 overrun clear pulse |
| maskEn | input | 4 | Per-source interrupt enable |
| extRaw | input | 2 | Raw transmit / receive-level sources |
| rdData | output | DW | Oldest queued frame |
| rxNotEmpty | output | 1 | Queue holds at least one frame |
| rawIrq | output | 4 | Unmasked interrupt status |
| maskedIrq | output | 4 | Masked interrupt status |
| combIrq | output | 1 | OR of masked sources |

## Verification
The bench targets the edges of the idle window: 31 against 32 ticks, ticks while a transfer is in flight, and restarts caused by a read or an overrun clear. A counter that is off by one, or that keeps counting during a transfer, would raise the timeout early.

It also times the overrun precisely. A design that flags the overrun at the transfer start, or that ignores a read that lands mid-frame, would set the overrun bit one stage early or lose the ninth frame.

Frames are sent while the overrun is still set. A design that keeps storing them shows a non-empty queue or wrong data after the clear.

// File: rtl/spRxIrqPkg.sv
package spRxIrqPkg;
  // interrupt bit positions
  localparam int IRQ_TO  = 0;
  localparam int IRQ_OVR = 1;
  localparam int IRQ_EX0 = 2;
  localparam int IRQ_EX1 = 3;
  localparam int NIRQ    = 4;

  // strobes from control to the queue datapath
  typedef struct packed {
    logic push;
    logic pop;
  } dpCtl_t;
endpackage

// File: rtl/spRxIrqDp.sv
module spRxIrqDp
  import spRxIrqPkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (ctl.push) wrPtr <= bump(wrPtr);
      if (ctl.pop)  rdPtr <= bump(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (ctl.push && wrPtr == PW'(i)) store[i] <= wrData;
    end
  end

  assign rdData = store[rdPtr];

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CW'(DEPTH)); // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (fill == '0) |-> !ctl.pop); // R2
endmodule

// File: rtl/spRxIrqCtl.sv
module spRxIrqCtl
  import spRxIrqPkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int IDLE_BITS = 32,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameDone,
  input  logic          xferStart,
  input  logic          bitTick,
  input  logic          rdEn,
  input  logic          ovrClr,
  input  logic [CW-1:0] fill,
  output dpCtl_t        ctl,
  output logic          rawTo,
  output logic          rawOvr
);
  localparam int IW = $clog2(IDLE_BITS + 1);

  logic          busy;
  logic          ovrFlag;
  logic [IW-1:0] idleCnt;
  logic          isEmpty, isFull, ovrSet, restart;

  assign isEmpty = (fill == '0);
  assign isFull  = (fill == CW'(DEPTH));

  assign ctl.pop  = rdEn && !isEmpty;
  assign ctl.push = frameDone && !ovrFlag && (!isFull || ctl.pop);
  assign ovrSet   = frameDone && !ovrFlag && isFull && !ctl.pop;

  assign restart  = xferStart || frameDone || ctl.pop || ovrClr || busy || isEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      ovrFlag <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (xferStart)      busy <= 1'b1;
      else if (frameDone) busy <= 1'b0;

      if (ovrSet)      ovrFlag <= 1'b1;
      else if (ovrClr) ovrFlag <= 1'b0;

      if (restart)
        idleCnt <= '0;
      else if (bitTick && idleCnt != IW'(IDLE_BITS))
        idleCnt <= idleCnt + 1'b1;
    end
  end

  assign rawTo  = (idleCnt == IW'(IDLE_BITS));
  assign rawOvr = ovrFlag;

  AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rawTo |-> (fill != '0)); // R11
  AST_START_DROPS_TO: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !rawTo); // R4
  AST_OVR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawOvr) |-> $past(frameDone)); // R6
  AST_CLR_DROPS_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClr && !frameDone) |=> !rawOvr); // R8
endmodule

// File: rtl/spRxIrq.sv
module spRxIrq
  import spRxIrqPkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 8,
  parameter int IDLE_BITS = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameDone,
  input  logic [DW-1:0] frameData,
  input  logic          xferStart,
  input  logic          bitTick,
  input  logic          rdEn,
  input  logic          ovrClr,
  input  logic [3:0]    maskEn,
  input  logic [1:0]    extRaw,
  output logic [DW-1:0] rdData,
  output logic          rxNotEmpty,
  output logic [3:0]    rawIrq,
  output logic [3:0]    maskedIrq,
  output logic          combIrq
);
  localparam int CW = $clog2(DEPTH + 1);

  dpCtl_t        dpCtl;
  logic [CW-1:0] fill;
  logic          rawTo, rawOvr;

  spRxIrqCtl #(.DEPTH(DEPTH), .IDLE_BITS(IDLE_BITS), .CW(CW)) uCtl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .xferStart(xferStart),
    .bitTick(bitTick), .rdEn(rdEn), .ovrClr(ovrClr), .fill(fill),
    .ctl(dpCtl), .rawTo(rawTo), .rawOvr(rawOvr)
  );

  spRxIrqDp #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .wrData(frameData),
    .rdData(rdData), .fill(fill)
  );

  assign rxNotEmpty = (fill != '0);

  always_comb begin
    rawIrq          = '0;
    rawIrq[IRQ_TO]  = rawTo;
    rawIrq[IRQ_OVR] = rawOvr;
    rawIrq[IRQ_EX0] = extRaw[0];
    rawIrq[IRQ_EX1] = extRaw[1];
  end

  for (genvar i = 0; i < NIRQ; i++) begin : gMask
    assign maskedIrq[i] = rawIrq[i] & maskEn[i];
  end

  assign combIrq = |maskedIrq;

  AST_OVR_FREEZES_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (rawOvr && !ovrClr) |=> (fill <= $past(fill))); // R8
  AST_COMB_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    combIrq |-> (rawIrq != '0)); // R10
endmodule

// File: tb/spRxIrq_test.sv
module spRxIrq_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameDone = 1'b0;
  logic [DW-1:0] frameData = '0;
  logic          xferStart = 1'b0;
  logic          bitTick = 1'b0;
  logic          rdEn = 1'b0;
  logic          ovrClr = 1'b0;
  logic [3:0]    maskEn = '0;
  logic [1:0]    extRaw = '0;
  logic [DW-1:0] rdData;
  logic          rxNotEmpty;
  logic [3:0]    rawIrq, maskedIrq;
  logic          combIrq;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spRxIrq uut (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameData(frameData),
    .xferStart(xferStart), .bitTick(bitTick), .rdEn(rdEn), .ovrClr(ovrClr),
    .maskEn(maskEn), .extRaw(extRaw), .rdData(rdData), .rxNotEmpty(rxNotEmpty),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq), .combIrq(combIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pushFrame(input logic [DW-1:0] d);
    xferStart = 1'b1; step(); xferStart = 1'b0;
    frameDone = 1'b1; frameData = d; step(); frameDone = 1'b0;
  endtask

  task automatic ticks(input int n);
    bitTick = 1'b1;
    for (int i = 0; i < n; i++) step();
    bitTick = 1'b0;
  endtask

  task automatic readOne(input string req, input logic [DW-1:0] exp);
    check(req, rdData, exp);
    rdEn = 1'b1; step(); rdEn = 1'b0;
  endtask

  task automatic tReset();
    check("R1 notEmpty", rxNotEmpty, 0);
    check("R1 raw", rawIrq, 0);
    check("R1 masked", maskedIrq, 0);
    check("R1 comb", combIrq, 0);
  endtask

  task automatic tOrder();
    pushFrame(16'hA001); pushFrame(16'hA002); pushFrame(16'hA003);
    check("R2 notEmpty", rxNotEmpty, 1);
    readOne("R2 first", 16'hA001);
    readOne("R2 second", 16'hA002);
    readOne("R2 third", 16'hA003);
    check("R2 drained", rxNotEmpty, 0);
    rdEn = 1'b1; step(); rdEn = 1'b0;
    check("R2 empty read", rxNotEmpty, 0);
    pushFrame(16'hA004);
    readOne("R2 after empty read", 16'hA004);
    check("R2 empty again", rxNotEmpty, 0);
  endtask

  task automatic tTimeout();
    maskEn = 4'b0001;
    pushFrame(16'hB001);
    ticks(31);
    check("R3 31 ticks", rawIrq[0], 0);
    ticks(1);
    check("R3 32 ticks", rawIrq[0], 1);
    check("R10 masked to", maskedIrq, 4'b0001);
    check("R10 comb to", combIrq, 1);
    xferStart = 1'b1; step(); xferStart = 1'b0;
    check("R4 start drops", rawIrq[0], 0);
    ticks(40);
    check("R4 busy ticks", rawIrq[0], 0);
    frameDone = 1'b1; frameData = 16'hB002; step(); frameDone = 1'b0;
    ticks(20);
    readOne("R5 read head", 16'hB001);
    ticks(31);
    check("R5 restarted 31", rawIrq[0], 0);
    ticks(1);
    check("R5 restarted 32", rawIrq[0], 1);
    readOne("R5 read last", 16'hB002);
    check("R11 drop on empty", rawIrq[0], 0);
    ticks(40);
    check("R11 empty no timeout", rawIrq[0], 0);
    maskEn = 4'b0000;
  endtask

  task automatic tOverrun();
    maskEn = 4'b0010;
    for (int i = 0; i < 8; i++) pushFrame(16'hC000 + 16'(i));
    xferStart = 1'b1; step(); xferStart = 1'b0;
    check("R6 not at start", rawIrq[1], 0);
    frameDone = 1'b1; frameData = 16'hC0FF; step(); frameDone = 1'b0;
    check("R6 after done", rawIrq[1], 1);
    check("R10 comb ovr", combIrq, 1);
    for (int i = 0; i < 8; i++) readOne("R6 kept data", 16'hC000 + 16'(i));
    check("R6 ninth dropped", rxNotEmpty, 0);
    pushFrame(16'hC100);
    check("R8 discarded while set", rxNotEmpty, 0);
    ovrClr = 1'b1; step(); ovrClr = 1'b0;
    check("R8 cleared", rawIrq[1], 0);
    pushFrame(16'hC200);
    check("R8 stored after clear", rxNotEmpty, 1);
    readOne("R8 data after clear", 16'hC200);
    maskEn = 4'b0000;
  endtask

  task automatic tReadDuring();
    for (int i = 0; i < 8; i++) pushFrame(16'hD000 + 16'(i));
    xferStart = 1'b1; step(); xferStart = 1'b0;
    readOne("R7 read mid frame", 16'hD000);
    frameDone = 1'b1; frameData = 16'hD008; step(); frameDone = 1'b0;
    check("R7 no overrun", rawIrq[1], 0);
    for (int i = 1; i < 9; i++) readOne("R7 order", 16'hD000 + 16'(i));
    check("R7 drained", rxNotEmpty, 0);
  endtask

  task automatic tClearTimeout();
    for (int i = 0; i < 8; i++) pushFrame(16'hE000 + 16'(i));
    pushFrame(16'hE0FF);
    check("R9 overrun set", rawIrq[1], 1);
    ticks(32);
    check("R9 timeout before clear", rawIrq[0], 1);
    ovrClr = 1'b1; step(); ovrClr = 1'b0;
    check("R9 clear restarts", rawIrq[0], 0);
    ticks(31);
    check("R9 31 after clear", rawIrq[0], 0);
    ticks(1);
    check("R9 32 after clear", rawIrq[0], 1);
    for (int i = 0; i < 8; i++) readOne("R9 drain", 16'hE000 + 16'(i));
    check("R9 empty", rxNotEmpty, 0);
  endtask

  task automatic tCombine();
    extRaw = 2'b10; maskEn = 4'b1000; #1;
    check("R10 raw ext1", rawIrq, 4'b1000);
    check("R10 comb ext1", combIrq, 1);
    maskEn = 4'b0100; #1;
    check("R10 masked off", maskedIrq, 0);
    check("R10 comb off", combIrq, 0);
    extRaw = 2'b01; #1;
    check("R10 masked ext0", maskedIrq, 4'b0100);
    check("R10 comb ext0", combIrq, 1);
    extRaw = 2'b00; maskEn = 4'b0000; step();
  endtask

  initial begin
    for (int i = 0; i < 50000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    step(); step();
    tReset();
    rstN = 1'b1; step();
    tReset();
    tOrder();
    tTimeout();
    tOverrun();
    tReadDuring();
    tClearTimeout();
    tCombine();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule